// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block is the device-side front end of a NAND flash target. On every write strobe it samples an 8-bit bus and qualifies the byte with the command latch enable, the address latch enable and an active-low chip enable. Command bytes are decoded into a current operation. Address bytes are packed into one address register, and the block counts the address cycles as they arrive. At defined points it fires single-cycle start pulses toward a back-end storage block. These cover read load, program setup, program commit, erase, ID, status, random read and reset.

Static configuration pins select the addressing scheme. One pin selects small-page or large-page addressing, one selects a device above or below 1 Gbit, and one selects a 16-bit data bus. These choices decide after how many address cycles a read or program starts, how an erase row is turned into a byte address, and whether the large-page confirm and random-read opcodes are honoured. Each pulse comes with the assembled address and the pending column offset, held on `op_addr` and `op_col_ofs`.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, `cur_cmd` is 0x00 and `addr_cycles`, `op_addr` and `op_col_ofs` are zero. No trigger is active.
- R2: A strobe with `ce_n` high changes neither `cur_cmd`, `addr_cycles` nor `op_addr`, and fires no trigger.
- R3: Each address byte (ALE high, CLE low) is written into `op_addr` at bits [8·n+7:8·n], where n is the cycle count before the byte. The bytes are therefore packed least-significant first. `addr_cycles` then increments and saturates at its maximum.
- R4: Opcode 0x00 sets `cur_cmd` to 0x00 and the column offset to 0. Opcode 0x01 sets `cur_cmd` to 0x00 and the offset to 0x100. Opcode 0x50 sets `cur_cmd` to 0x00 and the offset to the page size: 512 for small page, 2048 for large page.
- R5: While `cur_cmd` is 0x90, the first address cycle fires `trig_id`.
- R6: While `cur_cmd` is 0x00 (read) or 0x80 (program setup), a trigger fires on a fixed address cycle: `trig_read` or `trig_prog_start`. That cycle is the 3rd for small page, the 4th for large page at 1 Gbit or less, and the 5th for large page above 1 Gbit.
- R7: Every accepted command byte clears `addr_cycles`. The exception is 0xE0, which keeps the count.
- R8: In large-page mode, a 0x30 byte received while `cur_cmd` is 0x00 is ignored. In the same mode, 0x05 clears `op_addr[15:0]` and `addr_cycles` and leaves `cur_cmd` unchanged.
- R9: On 0xD0, `op_addr` keeps only the bytes received so far and is then shifted left by 8 (small page) or 16 (large page). `trig_erase` fires only if `wp_n` is high.
- R10: 0x10 fires `trig_prog_commit` only if `wp_n` is high.
- R11: 0x70 fires `trig_status`. 0xFF fires `trig_reset` and restores the state of R1.
- R12: With `cfg_wide_bus` high, `op_addr` is shifted left by one bit right after the second address cycle.
- R13: 0xE0 and 0x35 fire `trig_rnd_read` in large-page mode only.
- R14: An unknown opcode is stored in `cur_cmd` and fires no trigger. Every trigger lasts one cycle, and at most one trigger is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_large_page | input | 1 | 1 = large-page addressing |
| cfg_big_size | input | 1 | 1 = capacity above 1 Gbit |
| cfg_wide_bus | input | 1 | 1 = 16-bit data bus |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| io_we | input | 1 | Write strobe, one cycle per byte |
| io_data | input | 8 | Bus byte |
| trig_read | output | 1 | Read load start pulse |
| trig_prog_start | output | 1 | Program setup pulse |
| trig_prog_commit | output | 1 | Program commit pulse |
| trig_erase | output | 1 | Block erase pulse |
| trig_id | output | 1 | ID read pulse |
| trig_status | output | 1 | Status read pulse |
| trig_reset | output | 1 | Reset pulse |
| trig_rnd_read | output | 1 | Random read pulse |
| op_addr | output | 40 | Assembled address |
| op_col_ofs | output | 12 | Pending column offset |
| cur_cmd | output | 8 | Current stored opcode |
| addr_cycles | output | 4 | Address cycle count |

## Verification
The assertions check several rules on every cycle. At most one trigger is active. A strobe with chip enable high changes nothing. The cycle count either steps by one or clears, as the rules require. The protected commit and erase never fire while write protect is low. An ID pulse always lines up with the first address cycle of an ID command. A random-read pulse appears only in large-page mode. The scenarios are needed to show the values themselves. These are the byte packing, the trigger cycle for each geometry and size class, the offsets of the read variants, the masked and shifted erase address, and the 16-bit bus adjustment.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int ADDR_BYTES  = 5,
  parameter int OFS_W       = 12,
  parameter int SP_PAGE     = 512,
  parameter int LP_PAGE     = 2048,
  parameter int HALF_OFS    = 256,
  parameter int SP_COL_BITS = 8,
  parameter int LP_COL_BITS = 16,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int CNT_W      = $clog2(ADDR_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_large_page,
  input  logic              cfg_big_size,
  input  logic              cfg_wide_bus,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              wp_n,
  input  logic              io_we,
  input  logic [7:0]        io_data,
  output logic              trig_read,
  output logic              trig_prog_start,
  output logic              trig_prog_commit,
  output logic              trig_erase,
  output logic              trig_id,
  output logic              trig_status,
  output logic              trig_reset,
  output logic              trig_rnd_read,
  output logic [ADDR_W-1:0] op_addr,
  output logic [OFS_W-1:0]  op_col_ofs,
  output logic [7:0]        cur_cmd,
  output logic [CNT_W-1:0]  addr_cycles
);

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_READ_HI = 8'h01;
  localparam logic [7:0] OP_READ_SP = 8'h50;
  localparam logic [7:0] OP_LP_CONF = 8'h30;
  localparam logic [7:0] OP_NOSER   = 8'h35;
  localparam logic [7:0] OP_RND1    = 8'h05;
  localparam logic [7:0] OP_RND2    = 8'hE0;
  localparam logic [7:0] OP_ID      = 8'h90;
  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_PROG1   = 8'h80;
  localparam logic [7:0] OP_PROG2   = 8'h10;
  localparam logic [7:0] OP_ERASE1  = 8'h60;
  localparam logic [7:0] OP_ERASE2  = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  localparam int T_READ = 0, T_PSTART = 1, T_COMMIT = 2, T_ERASE = 3,
                 T_ID = 4, T_STATUS = 5, T_RESET = 6, T_RND = 7, NTRIG = 8;

  logic [7:0]        cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_q, addr_n, masked, erase_addr;
  logic [CNT_W-1:0]  cnt_q, cnt_n, launch;
  logic [OFS_W-1:0]  ofs_q, ofs_n;
  logic [NTRIG-1:0]  trig_q, trig_n;

  wire take = io_we && !ce_n;

  assign launch = !cfg_large_page ? CNT_W'(3) : (cfg_big_size ? CNT_W'(5) : CNT_W'(4));

  always_comb begin
    masked = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (CNT_W'(i) < cnt_q) masked[8*i +: 8] = addr_q[8*i +: 8];
    erase_addr = cfg_large_page ? (masked << LP_COL_BITS) : (masked << SP_COL_BITS);
  end

  always_comb begin
    cmd_n  = cmd_q;
    addr_n = addr_q;
    cnt_n  = cnt_q;
    ofs_n  = ofs_q;
    trig_n = '0;
    if (take && cle) begin
      if (cfg_large_page && cmd_q == OP_READ && io_data == OP_LP_CONF) begin
        cmd_n = cmd_q;
      end else if (cfg_large_page && io_data == OP_RND1) begin
        addr_n[LP_COL_BITS-1:0] = '0;
        cnt_n = '0;
      end else begin
        cmd_n = io_data;
        case (io_data)
          OP_READ:    ofs_n = '0;
          OP_READ_HI: begin cmd_n = OP_READ; ofs_n = OFS_W'(HALF_OFS); end
          OP_READ_SP: begin
            cmd_n = OP_READ;
            ofs_n = cfg_large_page ? OFS_W'(LP_PAGE) : OFS_W'(SP_PAGE);
          end
          OP_RESET: begin
            cmd_n  = OP_READ;
            addr_n = '0;
            ofs_n  = '0;
            trig_n[T_RESET] = 1'b1;
          end
          OP_STATUS: trig_n[T_STATUS] = 1'b1;
          OP_PROG2:  trig_n[T_COMMIT] = wp_n;
          OP_ERASE2: begin
            addr_n = erase_addr;
            trig_n[T_ERASE] = wp_n;
          end
          OP_RND2, OP_NOSER: trig_n[T_RND] = cfg_large_page;
          default: ;
        endcase
        if (io_data != OP_RND2) cnt_n = '0;
      end
    end else if (take && ale) begin
      for (int i = 0; i < ADDR_BYTES; i++)
        if (cnt_q == CNT_W'(i)) addr_n[8*i +: 8] = io_data;
      if (cnt_q != '1) cnt_n = cnt_q + 1'b1;
      if (cfg_wide_bus && cnt_n == CNT_W'(2)) addr_n = addr_n << 1;
      if (cmd_q == OP_ID && cnt_n == CNT_W'(1)) trig_n[T_ID] = 1'b1;
      if (cnt_n == launch) begin
        if (cmd_q == OP_READ)  trig_n[T_READ]   = 1'b1;
        if (cmd_q == OP_PROG1) trig_n[T_PSTART] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= OP_READ;
      addr_q <= '0;
      cnt_q  <= '0;
      ofs_q  <= '0;
      trig_q <= '0;
    end else begin
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
      ofs_q  <= ofs_n;
      trig_q <= trig_n;
    end
  end

  assign trig_read        = trig_q[T_READ];
  assign trig_prog_start  = trig_q[T_PSTART];
  assign trig_prog_commit = trig_q[T_COMMIT];
  assign trig_erase       = trig_q[T_ERASE];
  assign trig_id          = trig_q[T_ID];
  assign trig_status      = trig_q[T_STATUS];
  assign trig_reset       = trig_q[T_RESET];
  assign trig_rnd_read    = trig_q[T_RND];
  assign op_addr          = addr_q;
  assign op_col_ofs       = ofs_q;
  assign cur_cmd          = cmd_q;
  assign addr_cycles      = cnt_q;

  logic unused_erase1;
  assign unused_erase1 = (OP_ERASE1 == 8'h60);

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int ADDR_BYTES  = 5,
  parameter int OFS_W       = 12,
  parameter int LP_COL_BITS = 16,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int CNT_W      = $clog2(ADDR_BYTES) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_large_page,
  input logic              ce_n,
  input logic              cle,
  input logic              ale,
  input logic              wp_n,
  input logic              io_we,
  input logic [7:0]        io_data,
  input logic              trig_read,
  input logic              trig_prog_start,
  input logic              trig_prog_commit,
  input logic              trig_erase,
  input logic              trig_id,
  input logic              trig_status,
  input logic              trig_reset,
  input logic              trig_rnd_read,
  input logic [ADDR_W-1:0] op_addr,
  input logic [OFS_W-1:0]  op_col_ofs,
  input logic [7:0]        cur_cmd,
  input logic [CNT_W-1:0]  addr_cycles
);

  logic [7:0] trigs;
  assign trigs = {trig_rnd_read, trig_reset, trig_status, trig_id,
                  trig_erase, trig_prog_commit, trig_prog_start, trig_read};

  assert_one_trigger_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trigs));

  assert_ce_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && ce_n) |=> ($stable(cur_cmd) && $stable(addr_cycles) &&
                         $stable(op_addr) && trigs == 8'h00));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !ce_n && !cle && ale && addr_cycles != '1) |=>
      addr_cycles == $past(addr_cycles) + 1'b1);

  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !ce_n && cle && io_data != 8'hE0 &&
     !(cfg_large_page && cur_cmd == 8'h00 && io_data == 8'h30)) |=> addr_cycles == '0);

  assert_col_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !ce_n && cle && cfg_large_page && io_data == 8'h05) |=>
      ($stable(cur_cmd) && op_addr[LP_COL_BITS-1:0] == '0));

  assert_erase_wp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !ce_n && cle && io_data == 8'hD0 && !wp_n) |=> !trig_erase);

  assert_commit_wp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !ce_n && cle && io_data == 8'h10 && !wp_n) |=> !trig_prog_commit);

  assert_id_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_id |-> (addr_cycles == CNT_W'(1) && cur_cmd == 8'h90));

  assert_rnd_lp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rnd_read |-> cfg_large_page);

endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(
  .ADDR_BYTES(ADDR_BYTES), .OFS_W(OFS_W), .LP_COL_BITS(LP_COL_BITS)
) chk_i (.*);

// File: tb/nand_cmd_seq_tb_top.sv
module nand_cmd_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_large_page = 0, cfg_big_size = 0, cfg_wide_bus = 0;
  logic ce_n = 0, cle = 0, ale = 0, wp_n = 1, io_we = 0;
  logic [7:0] io_data = 0;
  logic t_rd, t_ps, t_pc, t_er, t_id, t_st, t_rs, t_rr;
  logic [39:0] op_addr;
  logic [11:0] op_col_ofs;
  logic [7:0]  cur_cmd;
  logic [3:0]  addr_cycles;
  logic [7:0]  got;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [7:0] X_RD = 8'h01, X_PS = 8'h02, X_PC = 8'h04, X_ER = 8'h08,
                         X_ID = 8'h10, X_ST = 8'h20, X_RS = 8'h40, X_RR = 8'h80;

  always #5ns clk = ~clk;

  nand_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_large_page(cfg_large_page),
    .cfg_big_size(cfg_big_size), .cfg_wide_bus(cfg_wide_bus), .ce_n(ce_n),
    .cle(cle), .ale(ale), .wp_n(wp_n), .io_we(io_we), .io_data(io_data),
    .trig_read(t_rd), .trig_prog_start(t_ps), .trig_prog_commit(t_pc),
    .trig_erase(t_er), .trig_id(t_id), .trig_status(t_st), .trig_reset(t_rs),
    .trig_rnd_read(t_rr), .op_addr(op_addr), .op_col_ofs(op_col_ofs),
    .cur_cmd(cur_cmd), .addr_cycles(addr_cycles));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(logic c, logic a, logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; io_data = d; io_we = 1;
    @(negedge clk);
    io_we = 0; cle = 0; ale = 0;
    got = {t_rr, t_rs, t_st, t_id, t_er, t_pc, t_ps, t_rd};
  endtask

  task automatic cmd(logic [7:0] d); put(1, 0, d); endtask
  task automatic adr(logic [7:0] d); put(0, 1, d); endtask

  task automatic setup(logic lp, logic big, logic wide);
    cfg_large_page = lp; cfg_big_size = big; cfg_wide_bus = wide; wp_n = 1; ce_n = 0;
    cmd(8'hFF);
  endtask

  task automatic t_reset_state;
    chk("R1 cmd", cur_cmd, 8'h00);
    chk("R1 cnt", addr_cycles, 0);
    chk("R1 addr", op_addr, 0);
    chk("R1 ofs", op_col_ofs, 0);
    chk("R1 trig", {t_rr, t_rs, t_st, t_id, t_er, t_pc, t_ps, t_rd}, 0);
  endtask

  task automatic t_sp_read;
    setup(0, 0, 0);
    cmd(8'h00); adr(8'h12); adr(8'h34);
    chk("R6 sp no early trig", got, 0);
    chk("R3 cnt two", addr_cycles, 2);
    adr(8'h56);
    chk("R6 sp read on 3rd", got, X_RD);
    chk("R3 byte order", op_addr, 40'h563412);
    adr(8'h78);
    chk("R6 no trig on 4th", got, 0);
    chk("R3 fourth byte", op_addr, 40'h78563412);
  endtask

  task automatic t_offsets;
    setup(0, 0, 0);
    cmd(8'h01);
    chk("R4 upper half ofs", op_col_ofs, 12'h100);
    chk("R4 upper half cmd", cur_cmd, 8'h00);
    cmd(8'h50);
    chk("R4 spare ofs sp", op_col_ofs, 12'h200);
    chk("R4 spare cmd", cur_cmd, 8'h00);
    cmd(8'h00);
    chk("R4 read clears ofs", op_col_ofs, 0);
    setup(1, 0, 0);
    cmd(8'h50);
    chk("R4 spare ofs lp", op_col_ofs, 12'h800);
  endtask

  task automatic t_lp_small;
    setup(1, 0, 0);
    cmd(8'h00); adr(8'h11); adr(8'h22); adr(8'h33);
    chk("R6 lp small no trig on 3rd", got, 0);
    adr(8'h44);
    chk("R6 lp small read on 4th", got, X_RD);
    cmd(8'h30);
    chk("R8 confirm ignored trig", got, 0);
    chk("R8 confirm ignored cnt", addr_cycles, 4);
    chk("R8 confirm ignored cmd", cur_cmd, 8'h00);
    cmd(8'h05);
    chk("R8 col clear addr", op_addr, 40'h44330000);
    chk("R8 col clear cnt", addr_cycles, 0);
    chk("R8 cmd kept", cur_cmd, 8'h00);
    adr(8'hAA); adr(8'hBB);
    cmd(8'hE0);
    chk("R13 rnd read lp", got, X_RR);
    chk("R7 E0 keeps cnt", addr_cycles, 2);
    chk("R8 new column", op_addr, 40'h4433BBAA);
    cmd(8'h35);
    chk("R13 noserial lp", got, X_RR);
    chk("R7 35 clears cnt", addr_cycles, 0);
  endtask

  task automatic t_lp_big;
    setup(1, 1, 0);
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04);
    chk("R6 lp big no trig on 4th", got, 0);
    adr(8'h05);
    chk("R6 lp big prog on 5th", got, X_PS);
    chk("R3 five bytes", op_addr, 40'h0504030201);
    put(0, 0, 8'h99);
    chk("R14 data byte no trig", got, 0);
    cmd(8'h10);
    chk("R10 commit wp high", got, X_PC);
  endtask

  task automatic t_read_id;
    setup(0, 0, 0);
    cmd(8'h90);
    chk("R5 no trig on cmd", got, 0);
    adr(8'h00);
    chk("R5 id on first cycle", got, X_ID);
    adr(8'h00);
    chk("R5 no id on second", got, 0);
  endtask

  task automatic t_erase;
    setup(0, 0, 0);
    adr(8'hEE); adr(8'hEE); adr(8'hEE);
    cmd(8'h60); adr(8'h01); adr(8'h02);
    chk("R9 no trig before confirm", got, 0);
    cmd(8'hD0);
    chk("R9 erase sp trig", got, X_ER);
    chk("R9 erase sp addr", op_addr, 40'h020100);
    setup(1, 0, 0);
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03);
    cmd(8'hD0);
    chk("R9 erase lp trig", got, X_ER);
    chk("R9 erase lp addr", op_addr, 40'h0302010000);
    setup(0, 0, 0);
    wp_n = 0;
    cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hD0);
    chk("R9 erase blocked by wp", got, 0);
    wp_n = 1;
  endtask

  task automatic t_program_wp;
    setup(0, 0, 0);
    wp_n = 0;
    cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h02);
    chk("R6 prog start sp", got, X_PS);
    cmd(8'h10);
    chk("R10 commit blocked by wp", got, 0);
    wp_n = 1;
  endtask

  task automatic t_wide;
    setup(0, 0, 1);
    cmd(8'h00); adr(8'h10); adr(8'h02);
    chk("R12 shift after 2nd", op_addr, 40'h0420);
    adr(8'h03);
    chk("R12 wide read trig", got, X_RD);
    chk("R12 wide addr", op_addr, 40'h030420);
  endtask

  task automatic t_status_reset;
    setup(0, 0, 0);
    cmd(8'h70);
    chk("R11 status trig", got, X_ST);
    chk("R11 status cmd", cur_cmd, 8'h70);
    cmd(8'h01); adr(8'h5A);
    cmd(8'hFF);
    chk("R11 reset trig", got, X_RS);
    chk("R11 reset cmd", cur_cmd, 8'h00);
    chk("R11 reset addr", op_addr, 0);
    chk("R11 reset ofs", op_col_ofs, 0);
    chk("R11 reset cnt", addr_cycles, 0);
  endtask

  task automatic t_unknown_ce;
    setup(0, 0, 0);
    cmd(8'h42);
    chk("R14 unknown no trig", got, 0);
    chk("R14 unknown stored", cur_cmd, 8'h42);
    cmd(8'hE0);
    chk("R13 no rnd in sp", got, 0);
    cmd(8'h05);
    chk("R8 05 plain in sp", cur_cmd, 8'h05);
    adr(8'h31);
    ce_n = 1;
    cmd(8'h90);
    chk("R2 ce high no trig", got, 0);
    chk("R2 ce high cmd kept", cur_cmd, 8'h05);
    adr(8'h77);
    chk("R2 ce high cnt kept", addr_cycles, 1);
    chk("R2 ce high addr kept", op_addr, 40'h31);
    ce_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_sp_read();
    t_offsets();
    t_lp_small();
    t_lp_big();
    t_read_id();
    t_erase();
    t_program_wp();
    t_wide();
    t_status_reset();
    t_unknown_ce();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule